// File: doc/BRIEF.md
# Branch-Guided Test Vector Generator

This block feeds a circuit under test with a stream of test vectors. Most bits are pseudorandom. For selected bit fields, the block instead walks through the values in order for a short run. Each field drives one conditional branch of the circuit. A small table of branch descriptors names the fields. A descriptor gives the field's starting bit position, its width and the number of branches the field selects between. The fields of the branch-controlling signals sit at the low end of the vector, one after another.

Software first fills the descriptor table through a write port while the block is idle. It then pulses `start` with a seed, a vector budget and a descriptor count. The generator visits the descriptors in index order. A descriptor whose branch count is dense enough for its width gets a deterministic run: that many vectors in which its field counts up from zero, while every other bit stays random. A descriptor that is not dense enough uses up one fully random vector. Once the table has been walked, the remaining vectors are fully random. Each vector is offered with a valid flag and leaves on a ready handshake. After the budgeted number of vectors has been accepted, the block raises `done`.

Top module: `branch_tpg`

## Requirements
- R1: After reset, `vec_valid`, `busy` and `done` are low. Every descriptor has width 0 and branch count 0, so a run started without any table writes is fully random.
- R2: `start` is taken while `busy` is low. The block then latches `seed`, `total_vecs` and `node_count`. On the next cycle `busy` and `vec_valid` are high, or `done` is high at once if `total_vecs` is 0. `start` has no effect while `busy` is high.
- R3: Random bits come from a 16-bit right-shifting Galois LFSR with feedback mask 0xB400. A zero seed is replaced by 1. Bit i of a vector is bit 0 of the state after i shifts. Each accepted vector advances the state by the vector width, so the first vector uses the seed itself.
- R4: Descriptor k, for k below `node_count` (capped at the table depth), qualifies only when its width X is at least 1 and 2·Y ≥ 2^X, where Y is its branch count.
- R5: A qualifying descriptor controls the next Y accepted vectors. In those vectors, bit offset+j for j < X carries bit X−1−j of v, where v is the count value (0, 1, … Y−1) taken modulo 2^X. The field's lowest bit therefore holds the most significant bit of v. All other bits stay random.
- R6: Descriptors are visited in index order. A non-qualifying descriptor uses up exactly one fully random vector. After the last descriptor, vectors are fully random.
- R7: A vector changes only when `vec_valid` and `vec_ready` are both high at a clock edge. Otherwise `vec_out` holds its value.
- R8: After `total_vecs` vectors have been accepted, `vec_valid` and `busy` drop and `done` stays high until the next `start`.
- R9: Descriptor writes are ignored while `busy` is high.
- R10: Any bit of a deterministic field that falls above the top vector bit is dropped. A width written above 4 is stored as 4, and a branch count written above 16 is stored as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken when not busy) |
| seed | input | LFSR_W | LFSR seed, zero replaced by 1 |
| total_vecs | input | CNT_W | Number of vectors in the run |
| node_count | input | IDX_W+1 | Number of descriptors to walk |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | IDX_W | Descriptor index to write |
| cfg_off | input | OFF_W | Field starting bit |
| cfg_x | input | X_W | Field width |
| cfg_y | input | Y_W | Branch count |
| vec_out | output | VEC_W | Current test vector |
| vec_valid | output | 1 | Vector on `vec_out` is valid |
| vec_ready | input | 1 | Consumer accepts the vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |

## Verification
The bench builds the block with a 9-bit vector and keeps the other defaults: 8 descriptors, widths up to 4, branch counts up to 16 and a 16-bit LFSR. With only 9 bits, a 1/2/3/3 field split fills the whole vector. This makes two effects easy to reach: a 3-bit field failing the density test, and a field placed at the top bit and cut off there. A bench LFSR model running in lockstep covers the random bits, so every bit of every vector is compared. The case where the branch count is larger than 2^X is covered as well, which makes the field counter wrap.

// File: rtl/tpg_pkg.sv
// Shared types and helpers for the branch-guided test vector generator.
// Assumes branch widths are small (at most a few bits) so int arithmetic suffices.
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    // Density test: branch count must cover at least half the field's code space.
    function automatic logic node_dense(input int x, input int y);
        return (x > 0) && ((2 * y) >= (1 << x));
    endfunction

endpackage

// File: rtl/tpg_desc_table.sv
// Descriptor storage: one field offset, width and branch count per entry.
// Assumes the caller gates writes while a run is active; clamps width and count.
module tpg_desc_table #(
    parameter int DEPTH = 8,
    parameter int OFF_W = 4,
    parameter int MAX_X = 4,
    parameter int MAX_Y = 16,
    parameter int X_W   = 3,
    parameter int Y_W   = 5,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [X_W-1:0]   wr_x,
    input  logic [Y_W-1:0]   wr_y,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [OFF_W-1:0] rd_off,
    output logic [X_W-1:0]   rd_x,
    output logic [Y_W-1:0]   rd_y,
    output logic             rd_dense
);
    import tpg_pkg::*;

    localparam logic [X_W-1:0] X_CAP = X_W'(MAX_X);
    localparam logic [Y_W-1:0] Y_CAP = Y_W'(MAX_Y);

    logic [OFF_W-1:0] off_q [DEPTH];
    logic [X_W-1:0]   x_q   [DEPTH];
    logic [Y_W-1:0]   y_q   [DEPTH];

    // Purpose: clear entries on reset, store clamped fields on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                off_q[i] <= '0;
                x_q[i]   <= '0;
                y_q[i]   <= '0;
            end
        end else if (wr_en) begin
            off_q[wr_idx] <= wr_off;
            x_q[wr_idx]   <= (wr_x > X_CAP) ? X_CAP : wr_x;
            y_q[wr_idx]   <= (wr_y > Y_CAP) ? Y_CAP : wr_y;
        end
    end

    // Purpose: present the addressed entry and its density verdict.
    always_comb begin
        rd_off   = off_q[rd_idx];
        rd_x     = x_q[rd_idx];
        rd_y     = y_q[rd_idx];
        rd_dense = node_dense(int'(x_q[rd_idx]), int'(y_q[rd_idx]));
    end

endmodule

// File: rtl/tpg_lfsr.sv
// Galois LFSR that yields OUT_W fresh bits per step by unrolling OUT_W shifts.
// Assumes TAPS is a maximal-length mask for a right-shifting register.
module tpg_lfsr #(
    parameter int              LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter int              OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              advance,
    output logic [LFSR_W-1:0] state_q,
    output logic [OUT_W-1:0]  rnd
);
    logic [LFSR_W-1:0] state_nx;

    // Purpose: take one output bit per shift and form the state OUT_W shifts ahead.
    always_comb begin
        logic [LFSR_W-1:0] s;
        s = state_q;
        for (int i = 0; i < OUT_W; i++) begin
            rnd[i] = s[0];
            s = (s >> 1) ^ (s[0] ? TAPS : '0);
        end
        state_nx = s;
    end

    // Purpose: load a nonzero seed on start, advance on each accepted vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LFSR_W'(1);
        else if (load)
            state_q <= (seed == '0) ? LFSR_W'(1) : seed;
        else if (advance)
            state_q <= state_nx;
    end

endmodule

// File: rtl/tpg_walker.sv
// Run controller: counts accepted vectors and walks the descriptor table.
// Assumes descriptor data for node_idx is presented combinationally.
module tpg_walker #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int Y_W   = 5,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     total,
    input  logic [IDX_W:0]       count,
    input  logic                 ready,
    input  logic                 node_dense,
    input  logic [Y_W-1:0]       node_y,
    output tpg_pkg::run_state_e  state,
    output logic [IDX_W:0]       node_idx,
    output logic [Y_W-1:0]       det_cnt,
    output logic                 det_active,
    output logic                 load_seed,
    output logic                 advance
);
    import tpg_pkg::*;

    localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] sent_q;
    logic [IDX_W:0]   ncnt_q;
    logic             node_live;

    // Purpose: derive handshake and field-control strobes from the run state.
    always_comb begin
        node_live  = (node_idx < ncnt_q);
        det_active = (state == ST_RUN) && node_live && node_dense;
        load_seed  = start && (state != ST_RUN);
        advance    = (state == ST_RUN) && ready;
    end

    // Purpose: sequence idle, run and done; step the descriptor walk per vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            total_q  <= '0;
            sent_q   <= '0;
            ncnt_q   <= '0;
            node_idx <= '0;
            det_cnt  <= '0;
        end else if (load_seed) begin
            total_q  <= total;
            sent_q   <= '0;
            ncnt_q   <= (count > DEPTH_V) ? DEPTH_V : count;
            node_idx <= '0;
            det_cnt  <= '0;
            state    <= (total == '0) ? ST_DONE : ST_RUN;
        end else if (advance) begin
            sent_q <= sent_q + CNT_W'(1);
            if (sent_q + CNT_W'(1) == total_q)
                state <= ST_DONE;
            if (node_live) begin
                if (node_dense && (det_cnt + Y_W'(1) != node_y)) begin
                    det_cnt <= det_cnt + Y_W'(1);
                end else begin
                    node_idx <= node_idx + (IDX_W+1)'(1);
                    det_cnt  <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/tpg_overlay.sv
// Replaces the random bits of one field with a count value, MSB at the lowest bit.
// Assumes x never exceeds MAX_X (the table clamps it) and cnt is wider than MAX_X.
module tpg_overlay #(
    parameter int VEC_W = 16,
    parameter int OFF_W = 4,
    parameter int X_W   = 3,
    parameter int Y_W   = 5,
    parameter int MAX_X = 4
) (
    input  logic [VEC_W-1:0] rnd,
    input  logic             det_active,
    input  logic [OFF_W-1:0] off,
    input  logic [X_W-1:0]   x,
    input  logic [Y_W-1:0]   cnt,
    output logic [VEC_W-1:0] vec
);
    // Purpose: splice count bits into the field, dropping bits above the vector.
    always_comb begin
        vec = rnd;
        if (det_active) begin
            for (int j = 0; j < MAX_X; j++) begin
                if ((j < int'(x)) && ((int'(off) + j) < VEC_W))
                    vec[int'(off) + j] = cnt[int'(x) - 1 - j];
            end
        end
    end

endmodule

// File: rtl/branch_tpg.sv
// Top of the branch-guided test vector generator.
// Assumes the descriptor table is written only between runs; vectors are
// combinational from registered state and move on a valid/ready handshake.
module branch_tpg #(
    parameter int                VEC_W  = 16,
    parameter int                DEPTH  = 8,
    parameter int                MAX_X  = 4,
    parameter int                MAX_Y  = 16,
    parameter int                LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
    parameter int                CNT_W  = 16,
    localparam int               OFF_W  = $clog2(VEC_W),
    localparam int               X_W    = $clog2(MAX_X + 1),
    localparam int               Y_W    = $clog2(MAX_Y + 1),
    localparam int               IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LFSR_W-1:0] seed,
    input  logic [CNT_W-1:0]  total_vecs,
    input  logic [IDX_W:0]    node_count,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [X_W-1:0]    cfg_x,
    input  logic [Y_W-1:0]    cfg_y,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid,
    input  logic              vec_ready,
    output logic              busy,
    output logic              done
);
    import tpg_pkg::*;

    run_state_e        state;
    logic [IDX_W:0]    node_idx;
    logic [Y_W-1:0]    det_cnt;
    logic              det_active;
    logic              load_seed;
    logic              advance;
    logic [OFF_W-1:0]  rd_off;
    logic [X_W-1:0]    rd_x;
    logic [Y_W-1:0]    rd_y;
    logic              rd_dense;
    logic [LFSR_W-1:0] lfsr_q;
    logic [VEC_W-1:0]  rnd;
    logic              table_we;

    // Purpose: decode status outputs and block table writes during a run.
    always_comb begin
        busy      = (state == ST_RUN);
        done      = (state == ST_DONE);
        vec_valid = busy;
        table_we  = cfg_we && !busy;
    end

    tpg_desc_table #(
        .DEPTH(DEPTH), .OFF_W(OFF_W), .MAX_X(MAX_X), .MAX_Y(MAX_Y),
        .X_W(X_W), .Y_W(Y_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(table_we), .wr_idx(cfg_idx), .wr_off(cfg_off),
        .wr_x(cfg_x), .wr_y(cfg_y),
        .rd_idx(node_idx[IDX_W-1:0]),
        .rd_off(rd_off), .rd_x(rd_x), .rd_y(rd_y), .rd_dense(rd_dense)
    );

    tpg_walker #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .Y_W(Y_W), .CNT_W(CNT_W)
    ) u_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .total(total_vecs),
        .count(node_count), .ready(vec_ready),
        .node_dense(rd_dense), .node_y(rd_y),
        .state(state), .node_idx(node_idx), .det_cnt(det_cnt),
        .det_active(det_active), .load_seed(load_seed), .advance(advance)
    );

    tpg_lfsr #(
        .LFSR_W(LFSR_W), .TAPS(TAPS), .OUT_W(VEC_W)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(load_seed), .seed(seed),
        .advance(advance), .state_q(lfsr_q), .rnd(rnd)
    );

    tpg_overlay #(
        .VEC_W(VEC_W), .OFF_W(OFF_W), .X_W(X_W), .Y_W(Y_W), .MAX_X(MAX_X)
    ) u_overlay (
        .rnd(rnd), .det_active(det_active), .off(rd_off), .x(rd_x),
        .cnt(det_cnt), .vec(vec_out)
    );

endmodule

// File: rtl/branch_tpg_checker.sv
// Protocol and state checks for branch_tpg, attached through bind.
// Assumes it sees the top's ports plus the LFSR state register.
module branch_tpg_checker #(
    parameter int VEC_W  = 16,
    parameter int LFSR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              vec_valid,
    input logic              vec_ready,
    input logic [VEC_W-1:0]  vec_out,
    input logic              busy,
    input logic              done,
    input logic [LFSR_W-1:0] lfsr_q
);
    // R7: a stalled vector is held unchanged
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_out)));

    // R8: done persists until a new start
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8: done only rises after an accepted vector or a zero-length start
    assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(vec_valid && vec_ready) || $past(start)));

    // R2: an idle start leads straight into a run or into done
    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done));

    // R3: the random source never reaches the all-zero lock-up state in a run
    assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lfsr_q != '0));
endmodule

bind branch_tpg branch_tpg_checker #(.VEC_W(VEC_W), .LFSR_W(LFSR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_out(vec_out), .busy(busy), .done(done),
    .lfsr_q(lfsr_q)
);

// File: tb/branch_tpg_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a table of expected field values for a 1/2/3/3 split,
// then directed runs compared bit for bit against a lockstep reference model.
module branch_tpg_tb;
    localparam int VW = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [15:0]     seed = '0;
    logic [15:0]     total_vecs = '0;
    logic [3:0]      node_count = '0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_idx = '0;
    logic [3:0]      cfg_off = '0;
    logic [2:0]      cfg_x = '0;
    logic [4:0]      cfg_y = '0;
    logic [VW-1:0]   vec_out;
    logic            vec_valid;
    logic            vec_ready = 1'b1;
    logic            busy;
    logic            done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int b_off [8];
    int b_x   [8];
    int b_y   [8];

    // Expected deterministic part of the worked configuration, one row per vector.
    localparam logic [VW-1:0] EXP_MASK [8] = '{9'h001, 9'h001, 9'h006, 9'h006,
                                               9'h006, 9'h000, 9'h000, 9'h000};
    localparam logic [VW-1:0] EXP_VAL  [8] = '{9'h000, 9'h001, 9'h000, 9'h004,
                                               9'h002, 9'h000, 9'h000, 9'h000};

    branch_tpg #(.VEC_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .total_vecs(total_vecs), .node_count(node_count),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_off(cfg_off),
        .cfg_x(cfg_x), .cfg_y(cfg_y),
        .vec_out(vec_out), .vec_valid(vec_valid), .vec_ready(vec_ready),
        .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lf_step(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [VW-1:0] lf_bits(input logic [15:0] s0);
        logic [15:0] s = s0;
        logic [VW-1:0] r;
        for (int i = 0; i < VW; i++) begin
            r[i] = s[0];
            s = lf_step(s);
        end
        return r;
    endfunction

    function automatic logic [15:0] lf_next(input logic [15:0] s0);
        logic [15:0] s = s0;
        for (int i = 0; i < VW; i++) s = lf_step(s);
        return s;
    endfunction

    function automatic bit qual(input int x, input int y);
        return (x >= 1) && (2 * y >= (1 << x));
    endfunction

    function automatic logic [VW-1:0] model_vec(input logic [15:0] s, input int nd,
                                                input int ct, input int n);
        logic [VW-1:0] r = lf_bits(s);
        if (nd < n && qual(b_x[nd], b_y[nd])) begin
            int v = ct % (1 << b_x[nd]);
            for (int j = 0; j < b_x[nd]; j++)
                if (b_off[nd] + j < VW) r[b_off[nd] + j] = v[b_x[nd] - 1 - j];
        end
        return r;
    endfunction

    task automatic write_node(input int i, input int off, input int x, input int y);
        cfg_idx = 3'(i); cfg_off = 4'(off); cfg_x = 3'(x); cfg_y = 5'(y); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        b_off[i] = off; b_x[i] = x; b_y[i] = y;
    endtask

    task automatic clear_model();
        for (int i = 0; i < 8; i++) begin b_off[i] = 0; b_x[i] = 0; b_y[i] = 0; end
    endtask

    // Starts a run and compares every vector with the reference model.
    task automatic run_cfg(input int total, input logic [15:0] sd, input int n,
                           input int stall_at, input string req);
        logic [15:0] ls;
        int nd = 0;
        int ct = 0;
        logic [VW-1:0] hold;
        seed = sd; total_vecs = 16'(total); node_count = 4'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ls = (sd == 16'h0) ? 16'h1 : sd;
        for (int k = 0; k < total; k++) begin
            if (k == stall_at) begin
                vec_ready = 1'b0;
                hold = vec_out;
                repeat (3) @(negedge clk);
                check("R7 stall hold", 32'(vec_out), 32'(hold));
                vec_ready = 1'b1;
            end
            check({req, " valid"}, 32'(vec_valid), 32'd1);
            check(req, 32'(vec_out), 32'(model_vec(ls, nd, ct, n)));
            @(negedge clk);
            ls = lf_next(ls);
            if (nd < n) begin
                if (qual(b_x[nd], b_y[nd]) && ct + 1 < b_y[nd]) ct++;
                else begin nd++; ct = 0; end
            end
        end
        check("R8 done", 32'(done), 32'd1);
        check("R8 valid low", 32'(vec_valid), 32'd0);
    endtask

    // Walks the expected-value table for the 1/2/3/3 split; optionally tries a busy write.
    task automatic run_table(input bit try_write);
        logic [15:0] ls = 16'h1D2B;
        seed = ls; total_vecs = 16'd8; node_count = 4'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            logic [VW-1:0] r = lf_bits(ls);
            if (try_write && k == 2) begin
                cfg_idx = 3'd0; cfg_off = 4'd5; cfg_x = 3'd4; cfg_y = 5'd16; cfg_we = 1'b1;
                start = 1'b1;
            end
            check(k == 5 ? "R6 failing node random" : "R5 field value",
                  32'(vec_out & EXP_MASK[k]), 32'(EXP_VAL[k]));
            check("R3 random bits", 32'(vec_out & ~EXP_MASK[k]), 32'(r & ~EXP_MASK[k]));
            @(negedge clk);
            cfg_we = 1'b0;
            start = 1'b0;
            ls = lf_next(ls);
        end
        check("R8 done after table", 32'(done), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(vec_valid), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        // R1: untouched table gives fully random vectors
        clear_model();
        run_cfg(3, 16'h5A5A, 8, -1, "R1 empty table");
        // R2: zero-length run goes straight to done
        seed = 16'h1; total_vecs = 16'd0; node_count = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 zero total done", 32'(done), 32'd1);
        check("R2 zero total busy", 32'(busy), 32'd0);
        // Worked configuration, then again after a write attempted mid-run (R9)
        write_node(0, 0, 1, 2);
        write_node(1, 1, 2, 3);
        write_node(2, 3, 3, 3);
        run_table(1'b1);
        run_table(1'b0);
        // R4 R5 R6 R7: mixed qualifying, failing and wrapping descriptors with a stall
        clear_model();
        write_node(0, 0, 2, 2);
        write_node(1, 2, 3, 4);
        write_node(2, 5, 4, 7);
        write_node(3, 6, 0, 1);
        write_node(4, 7, 1, 3);
        run_cfg(20, 16'hACE1, 5, 4, "R4 R5 R6 mixed");
        // R10 R3: field cut at the top bit, zero seed
        clear_model();
        write_node(0, 8, 2, 3);
        run_cfg(5, 16'h0000, 1, -1, "R10 top clip");
        // R10: oversize width and count are clamped to 4 and 16
        clear_model();
        write_node(0, 0, 7, 31);
        b_x[0] = 4; b_y[0] = 16;
        run_cfg(18, 16'h7001, 1, -1, "R10 clamp");
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule